// File: doc/BRIEF.md
# Keyed Error Interrupt Aggregator

This block gathers a vector of single-cycle hardware error or reset-cause events into sticky flag bits and produces one interrupt pulse for them. A global latch bit, kept at bit 0 of the flag word, lets exactly one pulse out. After that, no further pulse is issued until software acknowledges by clearing the latch. Software can still see, clear and force every source flag.

Software reaches the block through a simple 32-bit register port with four word offsets: flags (read only), clear (write 1 to clear), set (write 1 to force) and mask. The set and mask registers are guarded by a write key. They accept a write only when the write is full width and carries the key value 0xA5A5 in its upper half. The number of sources is a parameter. Source i owns flag bit i+1 and mask bit i+1.

Top module: `err_irq_gather`

## Requirements
- R1: After reset the flag word reads 0, `irq_pulse` is low, and the mask register reads its reset pattern. Mask bits are 0 except the positions chosen by `MASK_INIT`; the default `9'h030` makes the mask register read 0x60.
- R2: A `hw_evt[i]` high at a clock edge sets flag bit i+1 at that edge, unless mask bit i+1 is 1. A masked event leaves the flag at 0.
- R3: When some source flag is set and the global bit (flag bit 0) is 0, `irq_pulse` goes high for exactly one cycle starting at the next edge, and the global bit reads 1 from that same edge.
- R4: While the global bit is 1, `irq_pulse` stays low, even when new source flags become set.
- R5: A write to offset 2 clears every flag bit, the global bit included, whose data bit is 1 in an enabled byte lane. Data bits that are 0 have no effect, and offset 2 reads 0. If the global bit is cleared while source flags remain set, a new pulse follows one cycle later.
- R6: A keyed write to offset 4 forces to 1 each source flag whose data bit is 1. A forced flag triggers the pulse exactly as a hardware event does. Data bit 0 is ignored, so the global bit cannot be forced. Offset 4 reads 0.
- R7: Offsets 4 and 6 change state only for a write with all four byte enables set and data bits 31:16 equal to 0xA5A5. Any other key value, or a narrower write, changes nothing.
- R8: A keyed write to offset 6 loads mask bits 1..N_SRC from the data. Offset 6 reads these mask bits in place, with every other bit read as 0.
- R9: When a hardware event and a clear write hit the same flag bit in the same cycle, the flag ends up 1.
- R10: Bit 0 of the set and mask registers, bits above N_SRC, and offsets other than 0, 2, 4 and 6 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_evt | input | N_SRC | Single-cycle hardware event per source |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word offset (0, 2, 4, 6) |
| bus_be | input | 4 | Byte enables of the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
Two functions can land on the same cycle. One is a hardware event and a clear write on the same flag bit. The other is a global-bit clear while source flags are still pending. The bench raises `hw_evt` in the exact cycle that a clear write to offset 2 targets the same bit, and it clears bit 0 while a source flag stays set. It judges the first case by the flag word read back afterwards (the bit must survive). It judges the second by counting pulses against a cycle-by-cycle behavioural model.

// File: rtl/err_irq_pkg.sv
package err_irq_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam logic [15:0] WR_KEY   = 16'hA5A5;
    localparam int unsigned OFS_FLAG = 0;
    localparam int unsigned OFS_CLR  = 2;
    localparam int unsigned OFS_SET  = 4;
    localparam int unsigned OFS_MASK = 6;

    // decoded write: per-bit clear/set requests and a mask load
    typedef struct packed {
        logic [DATA_W-1:0] clr_bits;
        logic [DATA_W-1:0] set_bits;
        logic              mask_we;
        logic [DATA_W-1:0] mask_val;
    } wr_cmd_t;
endpackage

// File: rtl/err_wr_decode.sv
module err_wr_decode
    import err_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [3:0]          bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    output wr_cmd_t             cmd
);
    logic              key_ok;
    logic [DATA_W-1:0] lane_mask;

    always_comb begin
        key_ok    = bus_we && (bus_be == 4'hF) && (bus_wdata[31:16] == WR_KEY);
        lane_mask = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};
        cmd       = '0;
        if (bus_we && bus_addr == ADDR_W'(OFS_CLR)) begin
            cmd.clr_bits = bus_wdata & lane_mask;
        end
        if (key_ok && bus_addr == ADDR_W'(OFS_SET)) begin
            cmd.set_bits = bus_wdata;
        end
        if (key_ok && bus_addr == ADDR_W'(OFS_MASK)) begin
            cmd.mask_we  = 1'b1;
            cmd.mask_val = bus_wdata;
        end
    end
endmodule

// File: rtl/err_flag_bank.sv
module err_flag_bank #(
    parameter int unsigned        N_SRC     = 9,
    parameter logic [N_SRC-1:0]   MASK_INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] hw_evt,
    input  logic [N_SRC-1:0] clr_src,
    input  logic [N_SRC-1:0] set_src,
    input  logic             mask_we,
    input  logic [N_SRC-1:0] mask_val,
    output logic [N_SRC-1:0] src_q,
    output logic [N_SRC-1:0] mask_q
);
    typedef struct packed {
        logic [N_SRC-1:0] src;
        logic [N_SRC-1:0] mask;
    } bank_t;

    bank_t            st_d, st_q;
    logic [N_SRC-1:0] src_nxt;

    // per-source cell: any set request outranks a clear request
    for (genvar i = 0; i < N_SRC; i++) begin : g_cell
        logic set_req;
        assign set_req    = (hw_evt[i] & ~st_q.mask[i]) | set_src[i];
        assign src_nxt[i] = set_req | (st_q.src[i] & ~clr_src[i]);
    end

    always_comb begin
        st_d     = st_q;
        st_d.src = src_nxt;
        if (mask_we) begin
            st_d.mask = mask_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.src  <= '0;
            st_q.mask <= MASK_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_q  = st_q.src;
    assign mask_q = st_q.mask;
endmodule

// File: rtl/err_irq_latch.sv
module err_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic any_src,
    input  logic clr_glob,
    output logic glob_q,
    output logic irq_q
);
    typedef struct packed {
        logic glob;
        logic irq;
    } latch_t;

    latch_t st_d, st_q;
    logic   fire;

    always_comb begin
        fire      = ~st_q.glob & any_src;
        st_d.irq  = fire;
        st_d.glob = fire | (st_q.glob & ~clr_glob);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign glob_q = st_q.glob;
    assign irq_q  = st_q.irq;
endmodule

// File: rtl/err_read_mux.sv
module err_read_mux
    import err_irq_pkg::*;
#(
    parameter int unsigned N_SRC  = 9,
    parameter int unsigned ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_SRC-1:0]  src,
    input  logic              glob,
    input  logic [N_SRC-1:0]  mask,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (bus_addr == ADDR_W'(OFS_FLAG)) begin
            rdata[N_SRC:1] = src;
            rdata[0]       = glob;
        end else if (bus_addr == ADDR_W'(OFS_MASK)) begin
            rdata[N_SRC:1] = mask;
        end
    end
endmodule

// File: rtl/err_irq_gather.sv
module err_irq_gather
    import err_irq_pkg::*;
#(
    parameter int unsigned N_SRC     = 9,
    parameter int unsigned ADDR_W    = 3,
    parameter logic [30:0] MASK_INIT = 31'h030
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  hw_evt,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_pulse
);
    wr_cmd_t          cmd;
    logic [N_SRC-1:0] src_w;
    logic [N_SRC-1:0] mask_w;
    logic [N_SRC-1:0] set_w;
    logic             glob_w;
    logic             unused_cmd;

    assign set_w      = cmd.set_bits[N_SRC:1];
    assign unused_cmd = ^cmd;

    err_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .cmd       (cmd)
    );

    err_flag_bank #(.N_SRC(N_SRC), .MASK_INIT(MASK_INIT[N_SRC-1:0])) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_evt   (hw_evt),
        .clr_src  (cmd.clr_bits[N_SRC:1]),
        .set_src  (set_w),
        .mask_we  (cmd.mask_we),
        .mask_val (cmd.mask_val[N_SRC:1]),
        .src_q    (src_w),
        .mask_q   (mask_w)
    );

    err_irq_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_src  (|src_w),
        .clr_glob (cmd.clr_bits[0]),
        .glob_q   (glob_w),
        .irq_q    (irq_pulse)
    );

    err_read_mux #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_rd (
        .bus_addr (bus_addr),
        .src      (src_w),
        .glob     (glob_w),
        .mask     (mask_w),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/err_irq_gather_chk.sv
module err_irq_gather_chk
    import err_irq_pkg::*;
#(
    parameter int unsigned N_SRC  = 9,
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  hw_evt,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_be,
    input logic [31:0]       bus_wdata,
    input logic              irq_pulse,
    input logic              glob_w,
    input logic [N_SRC-1:0]  src_w,
    input logic [N_SRC-1:0]  mask_w,
    input logic [N_SRC-1:0]  set_w
);
    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    assert_pulse_latches_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> glob_w);

    assert_no_pulse_latched_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> !$past(glob_w));

    assert_flag_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_w & ~$past(src_w) & ~($past(hw_evt) & ~$past(mask_w)) & ~$past(set_w)) == '0));

    assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_evt & ~mask_w) != '0) |=>
        ((src_w & $past(hw_evt & ~mask_w)) == $past(hw_evt & ~mask_w)));

    assert_bad_key_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_MASK) &&
         (bus_be != 4'hF || bus_wdata[31:16] != WR_KEY)) |=> $stable(mask_w));
endmodule

bind err_irq_gather err_irq_gather_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_evt    (hw_evt),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .irq_pulse (irq_pulse),
    .glob_w    (glob_w),
    .src_w     (src_w),
    .mask_w    (mask_w),
    .set_w     (set_w)
);

// File: tb/sim_err_irq_gather.sv
`timescale 1ns/1ps
module sim_err_irq_gather;
    localparam int N = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  hw_evt = '0;
    logic          bus_we = 1'b0;
    logic [2:0]    bus_addr = 3'd0;
    logic [3:0]    bus_be = 4'h0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_pulse;

    int    n_chk = 0;
    int    n_fail = 0;
    int    pcount = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference state
    bit [N-1:0] m_src;
    bit         m_glob;
    bit [N-1:0] m_msk;
    bit         m_irq;

    always #10 clk = ~clk;

    err_irq_gather u0 (
        .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_pulse(irq_pulse)
    );

    function automatic bit [31:0] mdl_read(input bit [2:0] a);
        bit [31:0] r;
        r = 0;
        if (a == 3'd0) begin
            for (int k = 0; k < N; k++) r[k+1] = m_src[k];
            r[0] = m_glob;
        end else if (a == 3'd6) begin
            for (int k = 0; k < N; k++) r[k+1] = m_msk[k];
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_src  <= '0;
            m_glob <= 1'b0;
            m_msk  <= 9'h030;
            m_irq  <= 1'b0;
        end else begin
            bit        keyed;
            bit [31:0] clr;
            bit [N-1:0] nsrc;
            bit        pend;
            keyed = bus_we && bus_be == 4'hF && bus_wdata[31:16] == 16'hA5A5;
            clr = 0;
            if (bus_we && bus_addr == 3'd2)
                for (int k = 0; k < 32; k++) clr[k] = bus_wdata[k] & bus_be[k/8];
            pend = (m_src != 0);
            for (int k = 0; k < N; k++) begin
                nsrc[k] = m_src[k];
                if (clr[k+1]) nsrc[k] = 1'b0;
                if (hw_evt[k] && !m_msk[k]) nsrc[k] = 1'b1;
                if (keyed && bus_addr == 3'd4 && bus_wdata[k+1]) nsrc[k] = 1'b1;
            end
            m_src <= nsrc;
            m_irq <= !m_glob && pend;
            if (!m_glob && pend) m_glob <= 1'b1;
            else if (clr[0]) m_glob <= 1'b0;
            if (keyed && bus_addr == 3'd6)
                for (int k = 0; k < N; k++) m_msk[k] <= bus_wdata[k+1];
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if (irq_pulse !== m_irq || bus_rdata !== mdl_read(bus_addr)) begin
                n_fail++;
                $display("FAIL %s model compare: irq=%0b rdata=%h expected irq=%0b rdata=%h",
                         cur_req, irq_pulse, bus_rdata, m_irq, mdl_read(bus_addr));
            end
            if (irq_pulse) pcount++;
        end
    end

    task automatic check_eq(input string req, input string what, input logic [31:0] act,
                            input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input bit [2:0] a, input bit [31:0] d, input bit [3:0] be);
        @(posedge clk); #2;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(posedge clk); #2;
        bus_we = 1'b0; bus_be = 4'h0; bus_wdata = '0; bus_addr = 3'd0;
    endtask

    task automatic evt(input bit [N-1:0] v);
        @(posedge clk); #2;
        hw_evt = v;
        @(posedge clk); #2;
        hw_evt = '0;
    endtask

    task automatic rd_chk(input string req, input bit [2:0] a, input bit [31:0] exp);
        @(posedge clk); #2;
        bus_addr = a;
        @(negedge clk);
        check_eq(req, $sformatf("read offset %0d", a), bus_rdata, exp);
        #12;
        bus_addr = 3'd0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        cur_req = "R1";
        check_eq("R1", "irq after reset", {31'b0, irq_pulse}, 32'h0);
        rd_chk("R1", 3'd0, 32'h0);
        rd_chk("R1", 3'd6, 32'h60);

        // R2/R3 first event gives one pulse
        cur_req = "R3"; pcount = 0;
        evt(9'h001); tick(3);
        rd_chk("R2", 3'd0, 32'h3);
        check_eq("R3", "pulse count", pcount, 1);

        // R4 latched: no more pulses
        cur_req = "R4";
        evt(9'h004); tick(3);
        rd_chk("R4", 3'd0, 32'hB);
        check_eq("R4", "pulse count while latched", pcount, 1);

        // R5 clear
        cur_req = "R5";
        wr(3'd2, 32'h0000_0002, 4'hF);
        rd_chk("R5", 3'd0, 32'h9);
        rd_chk("R5", 3'd2, 32'h0);
        pcount = 0;
        wr(3'd2, 32'h0000_0001, 4'hF); tick(3);
        check_eq("R5", "re-pulse after global clear", pcount, 1);
        rd_chk("R5", 3'd0, 32'h9);
        wr(3'd2, 32'hFFFF_FFFF, 4'hF); tick(2);
        rd_chk("R5", 3'd0, 32'h0);
        check_eq("R5", "no pulse after full clear", pcount, 1);

        // R7/R8/R10 mask access
        cur_req = "R7";
        wr(3'd6, 32'h1234_0004, 4'hF);
        rd_chk("R7", 3'd6, 32'h60);
        wr(3'd6, 32'hA5A5_0004, 4'h3);
        rd_chk("R7", 3'd6, 32'h60);
        cur_req = "R8";
        wr(3'd6, 32'hA5A5_0007, 4'hF);
        rd_chk("R8", 3'd6, 32'h6);

        // R2 masking
        cur_req = "R2"; pcount = 0;
        evt(9'h001); tick(3);
        rd_chk("R2", 3'd0, 32'h0);
        check_eq("R2", "no pulse for masked event", pcount, 0);
        evt(9'h008); tick(3);
        rd_chk("R2", 3'd0, 32'h11);
        check_eq("R2", "pulse for unmasked event", pcount, 1);

        // R6/R7 set register
        cur_req = "R6";
        wr(3'd2, 32'hFFFF_FFFF, 4'hF); tick(2);
        wr(3'd4, 32'h5A5A_0040, 4'hF); tick(1);
        rd_chk("R7", 3'd0, 32'h0);
        wr(3'd4, 32'hA5A5_0040, 4'h7); tick(1);
        rd_chk("R7", 3'd0, 32'h0);
        pcount = 0;
        wr(3'd4, 32'hA5A5_0001, 4'hF); tick(2);
        rd_chk("R6", 3'd0, 32'h0);
        wr(3'd4, 32'hA5A5_0041, 4'hF); tick(3);
        rd_chk("R6", 3'd0, 32'h41);
        check_eq("R6", "pulse from forced flag", pcount, 1);
        rd_chk("R6", 3'd4, 32'h0);

        // R9 event beats clear in the same cycle
        cur_req = "R9";
        wr(3'd2, 32'hFFFF_FFFF, 4'hF); tick(2);
        @(posedge clk); #2;
        hw_evt = 9'h004;
        bus_we = 1'b1; bus_addr = 3'd2; bus_wdata = 32'h0000_0008; bus_be = 4'hF;
        @(posedge clk); #2;
        hw_evt = '0; bus_we = 1'b0; bus_be = 4'h0; bus_wdata = '0; bus_addr = 3'd0;
        tick(3);
        rd_chk("R9", 3'd0, 32'h9);

        // R10 reserved offsets
        cur_req = "R10";
        wr(3'd1, 32'hA5A5_FFFF, 4'hF);
        wr(3'd3, 32'hFFFF_FFFF, 4'hF);
        wr(3'd7, 32'hA5A5_FFFF, 4'hF);
        wr(3'd5, 32'hA5A5_FFFF, 4'hF);
        rd_chk("R10", 3'd1, 32'h0);
        rd_chk("R10", 3'd3, 32'h0);
        rd_chk("R10", 3'd5, 32'h0);
        rd_chk("R10", 3'd7, 32'h0);
        rd_chk("R10", 3'd0, 32'h9);
        rd_chk("R10", 3'd6, 32'h6);

        tick(2);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule